// File: doc/BRIEF.md
# Function Event and Wake Register Block

This block keeps the function-level event state of a card-bus style peripheral and turns it into two signals for the host. Events are latched in an event register, either from a rising edge of the general-wake present-state input or from a write to a force register. A mask register decides whether a latched or present interrupt condition reaches the active-low interrupt pin (interface powered) or the active-high wake pin (interface unpowered). A general-wake event reaches the wake pin only when both its own mask and the global wake mask are set.

Software reaches the registers through a simple read/write port at byte offsets F0h (events), F4h (masks), F8h (present state) and FCh (force). The port works only while both the card-enable and the function-register-enable inputs are high. Register contents are cleared only by the power-on reset. The bus reset does not touch them. The software reset clears only the general-wake event.

Top module: `fn_event_wake`

## Requirements
- R1: After `por_rst`, `int_n` is 1, `wake` is 0, and the event register (F0h) and mask register (F4h) both read 0.
- R2: Asserting `bus_rst` changes neither the event register nor the mask register.
- R3: While `card_en` and `freg_en` are not both 1, writes are ignored and every read returns 0.
- R4: Only mask bits 15 (interrupt mask), 14 (global wake mask) and 4 (general-wake mask) can be written at F4h. All other bits read 0, so writing all ones reads back 0x0000C010.
- R5: A 0-to-1 change of `ps_gwake` sets event bit 4 at F0h. Holding `ps_gwake` high does not set the bit again after it has been cleared.
- R6: A write to FCh with bit 15 set sets event bit 15 (interrupt), and with bit 4 set sets event bit 4 (general wake). FCh always reads 0.
- R7: Writing 1 to an event bit at F0h clears it, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins, so the bit ends up 1.
- R8: F8h reads `ps_intr` at bit 15 and `ps_gwake` at bit 4, with all other bits 0. Writes to F8h have no effect.
- R9: `int_n` is a register that goes low one cycle after `pwr_on`, interrupt mask and (event bit 15 or `ps_intr`) are all 1. Otherwise it is high.
- R10: `wake` is a register that goes high one cycle after the global wake mask is 1 and either (general-wake mask and event bit 4 are 1) or (`pwr_on` is 0, the interrupt mask is 1 and event bit 15 or `ps_intr` is 1).
- R11: `int_n` never goes low while the interface is unpowered.
- R12: `sw_rst` clears event bit 4 but leaves event bit 15 and all mask bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high; clears all state |
| bus_rst | input | 1 | Bus reset; clears only the read data register |
| sw_rst | input | 1 | Software reset; clears the general-wake event |
| card_en | input | 1 | Card enable; gates register access |
| freg_en | input | 1 | Function register enable; gates register access |
| pwr_on | input | 1 | High while the host interface is powered |
| ps_intr | input | 1 | Present-state interrupt condition |
| ps_gwake | input | 1 | Present-state general-wake condition |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| int_n | output | 1 | Interrupt, active low |
| wake | output | 1 | System wake, active high |

## Verification
The bench sweeps all combinations of power state, the three mask bits, both event bits and the present interrupt input, and compares both outputs against the routing formula. A design that swapped the power routing, or that ignored the global wake mask, would show the wrong pin in part of that sweep. Targeted sequences check the ordering corner cases. A clear that lands in the same cycle as a `ps_gwake` edge must leave the bit set. A level held high must not set the bit again. The software reset must drop only the general-wake event, so a design that cleared all state on either reset would lose bits the bench reads back.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned FE_OFS_EVT = 32'hF0;
  localparam int unsigned FE_OFS_MSK = 32'hF4;
  localparam int unsigned FE_OFS_PST = 32'hF8;
  localparam int unsigned FE_OFS_FRC = 32'hFC;

  localparam int unsigned FE_BIT_INTR = 15;
  localparam int unsigned FE_BIT_WKUP = 14;
  localparam int unsigned FE_BIT_GW   = 4;

  typedef struct packed {
    logic intr;
    logic gwake;
  } fe_flags_t;

  typedef struct packed {
    logic intr;
    logic wkup;
    logic gwake;
  } fe_mask_t;
endpackage

// File: rtl/fe_edge.sv
module fe_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/fe_regs.sv
module fe_regs
  import fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              sw_rst,
  input  logic              acc_ok,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  fe_flags_t         ps,
  input  logic              edge_gw,
  output fe_flags_t         ev,
  output fe_mask_t          msk,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(FE_OFS_EVT);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(FE_OFS_MSK);
  localparam logic [ADDR_W-1:0] A_PST = ADDR_W'(FE_OFS_PST);

  logic wr_evt, wr_msk, wr_frc;
  logic set_intr, set_gw, clr_intr, clr_gw;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_evt   = acc_ok && wr_en && (addr == A_EVT);
    wr_msk   = acc_ok && wr_en && (addr == A_MSK);
    wr_frc   = acc_ok && wr_en && (addr == ADDR_W'(FE_OFS_FRC));
    set_intr = wr_frc && wdata[FE_BIT_INTR];
    set_gw   = edge_gw || (wr_frc && wdata[FE_BIT_GW]);
    clr_intr = wr_evt && wdata[FE_BIT_INTR];
    clr_gw   = wr_evt && wdata[FE_BIT_GW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev  <= '0;
      msk <= '0;
    end else begin
      ev.intr <= (ev.intr & ~clr_intr) | set_intr;
      if (sw_rst) ev.gwake <= 1'b0;
      else        ev.gwake <= (ev.gwake & ~clr_gw) | set_gw;
      if (wr_msk) begin
        msk.intr  <= wdata[FE_BIT_INTR];
        msk.wkup  <= wdata[FE_BIT_WKUP];
        msk.gwake <= wdata[FE_BIT_GW];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_EVT: begin
        rd_mux[FE_BIT_INTR] = ev.intr;
        rd_mux[FE_BIT_GW]   = ev.gwake;
      end
      A_MSK: begin
        rd_mux[FE_BIT_INTR] = msk.intr;
        rd_mux[FE_BIT_WKUP] = msk.wkup;
        rd_mux[FE_BIT_GW]   = msk.gwake;
      end
      A_PST: begin
        rd_mux[FE_BIT_INTR] = ps.intr;
        rd_mux[FE_BIT_GW]   = ps.gwake;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) rdata <= '0;
    else if (rd_en)     rdata <= acc_ok ? rd_mux : '0;
  end
endmodule

// File: rtl/fe_route.sv
module fe_route
  import fe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pwr_on,
  input  fe_flags_t ev,
  input  fe_flags_t ps,
  input  fe_mask_t  msk,
  output logic      int_n,
  output logic      wake
);
  logic intr_any, int_hit, wake_hit;

  always_comb begin
    intr_any = ev.intr | ps.intr;
    int_hit  = pwr_on & msk.intr & intr_any;
    wake_hit = msk.wkup & ((msk.gwake & ev.gwake) | (~pwr_on & msk.intr & intr_any));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n <= 1'b1;
      wake  <= 1'b0;
    end else begin
      int_n <= ~int_hit;
      wake  <= wake_hit;
    end
  end
endmodule

// File: rtl/fn_event_wake.sv
module fn_event_wake
  import fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              bus_rst,
  input  logic              sw_rst,
  input  logic              card_en,
  input  logic              freg_en,
  input  logic              pwr_on,
  input  logic              ps_intr,
  input  logic              ps_gwake,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              int_n,
  output logic              wake
);
  fe_flags_t ps_w, ev_w;
  fe_mask_t  msk_w;
  logic      gw_rise;
  logic      acc_ok;

  assign acc_ok   = card_en & freg_en;
  assign ps_w.intr  = ps_intr;
  assign ps_w.gwake = ps_gwake;

  fe_edge u_edge (
    .clk   (clk),
    .rst   (por_rst),
    .level (ps_gwake),
    .rise  (gw_rise)
  );

  fe_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (por_rst),
    .bus_rst (bus_rst),
    .sw_rst  (sw_rst),
    .acc_ok  (acc_ok),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .ps      (ps_w),
    .edge_gw (gw_rise),
    .ev      (ev_w),
    .msk     (msk_w),
    .rdata   (rdata)
  );

  fe_route u_route (
    .clk    (clk),
    .rst    (por_rst),
    .pwr_on (pwr_on),
    .ev     (ev_w),
    .ps     (ps_w),
    .msk    (msk_w),
    .int_n  (int_n),
    .wake   (wake)
  );
endmodule

// File: rtl/fe_checker.sv
module fe_checker
  import fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              por_rst,
  input logic              card_en,
  input logic              freg_en,
  input logic              pwr_on,
  input logic              ps_gwake,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              int_n,
  input logic              wake,
  input logic              ev_intr,
  input logic              ev_gwake,
  input logic [2:0]        msk_bits
);
  logic frc_gw_wr, evt_intr_clr, any_wr;

  always_comb begin
    any_wr       = wr_en && card_en && freg_en;
    frc_gw_wr    = any_wr && (addr == ADDR_W'(FE_OFS_FRC)) && wdata[FE_BIT_GW];
    evt_intr_clr = any_wr && (addr == ADDR_W'(FE_OFS_EVT)) && wdata[FE_BIT_INTR];
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (por_rst)
    $past(por_rst) |-> (int_n && !wake));

  assert_mask_only_by_write_R2: assert property (@(posedge clk) disable iff (por_rst)
    !any_wr |=> $stable(msk_bits));

  assert_gwake_has_source_R5: assert property (@(posedge clk) disable iff (por_rst)
    $rose(ev_gwake) |-> ($past(ps_gwake) || $past(frc_gw_wr)));

  assert_intr_clear_by_write_R7: assert property (@(posedge clk) disable iff (por_rst)
    $fell(ev_intr) |-> $past(evt_intr_clr));

  assert_wake_needs_wkup_R10: assert property (@(posedge clk) disable iff (por_rst)
    !$past(msk_bits[1]) |-> !wake);

  assert_no_int_unpowered_R11: assert property (@(posedge clk) disable iff (por_rst)
    !$past(pwr_on) |-> int_n);
endmodule

bind fn_event_wake fe_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .por_rst  (por_rst),
  .card_en  (card_en),
  .freg_en  (freg_en),
  .pwr_on   (pwr_on),
  .ps_gwake (ps_gwake),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .int_n    (int_n),
  .wake     (wake),
  .ev_intr  (ev_w.intr),
  .ev_gwake (ev_w.gwake),
  .msk_bits ({msk_w.intr, msk_w.wkup, msk_w.gwake})
);

// File: tb/fn_event_wake_bench.sv
`timescale 1ns/1ps
module fn_event_wake_bench;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, bus_rst = 1'b0, sw_rst = 1'b0;
  logic        card_en = 1'b1, freg_en = 1'b1, pwr_on = 1'b1;
  logic        ps_intr = 1'b0, ps_gwake = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        int_n, wake;

  int checks = 0;
  int fails  = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  fn_event_wake u_fn_event_wake (
    .clk(clk), .por_rst(por_rst), .bus_rst(bus_rst), .sw_rst(sw_rst),
    .card_en(card_en), .freg_en(freg_en), .pwr_on(pwr_on),
    .ps_intr(ps_intr), .ps_gwake(ps_gwake), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .int_n(int_n), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #500000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_n", {31'd0, int_n}, 32'd1);
    chk("R1 wake", {31'd0, wake}, 32'd0);
    rd(8'hF0, v); chk("R1 event", v, 32'h0);
    rd(8'hF4, v); chk("R1 mask", v, 32'h0);

    // R4 mask writable bits
    wr(8'hF4, 32'hFFFF_FFFF);
    rd(8'hF4, v); chk("R4 mask all ones", v, 32'h0000_C010);

    // R3 access gating
    card_en = 1'b0;
    wr(8'hF4, 32'h0);
    rd(8'hF4, v); chk("R3 read while disabled", v, 32'h0);
    card_en = 1'b1; freg_en = 1'b0;
    wr(8'hFC, 32'h8010);
    freg_en = 1'b1;
    rd(8'hF4, v); chk("R3 write ignored mask", v, 32'h0000_C010);
    rd(8'hF0, v); chk("R3 write ignored force", v, 32'h0);

    // R6 force register
    wr(8'hF4, 32'h0);
    wr(8'hFC, 32'h0000_8000);
    rd(8'hF0, v); chk("R6 force intr", v, 32'h0000_8000);
    wr(8'hFC, 32'h0000_0010);
    rd(8'hF0, v); chk("R6 force gwake", v, 32'h0000_8010);
    rd(8'hFC, v); chk("R6 force reads zero", v, 32'h0);

    // R7 write one to clear
    wr(8'hF0, 32'h0000_0000);
    rd(8'hF0, v); chk("R7 write zero no effect", v, 32'h0000_8010);
    wr(8'hF0, 32'h0000_8000);
    rd(8'hF0, v); chk("R7 clear intr", v, 32'h0000_0010);
    wr(8'hF0, 32'h0000_0010);
    rd(8'hF0, v); chk("R7 clear gwake", v, 32'h0);

    // R2 bus reset keeps state, R12 software reset
    wr(8'hF4, 32'h0000_C010);
    wr(8'hFC, 32'h0000_8010);
    bus_rst = 1'b1; repeat (3) @(negedge clk); bus_rst = 1'b0;
    rd(8'hF0, v); chk("R2 event kept", v, 32'h0000_8010);
    rd(8'hF4, v); chk("R2 mask kept", v, 32'h0000_C010);
    sw_rst = 1'b1; repeat (2) @(negedge clk); sw_rst = 1'b0;
    rd(8'hF0, v); chk("R12 sw reset event", v, 32'h0000_8000);
    rd(8'hF4, v); chk("R12 sw reset mask", v, 32'h0000_C010);
    wr(8'hF0, 32'h0000_8010);

    // R5 edge detection
    ps_gwake = 1'b1; repeat (2) @(negedge clk);
    rd(8'hF0, v); chk("R5 rising edge sets", v, 32'h0000_0010);
    wr(8'hF0, 32'h0000_0010);
    repeat (3) @(negedge clk);
    rd(8'hF0, v); chk("R5 held level no reset", v, 32'h0);
    ps_gwake = 1'b0; repeat (2) @(negedge clk);
    wr(8'hFC, 32'h0000_0010);
    ps_gwake = 1'b1;
    wr(8'hF0, 32'h0000_0010);
    rd(8'hF0, v); chk("R7 edge beats clear", v, 32'h0000_0010);
    ps_gwake = 1'b0;
    wr(8'hF0, 32'h0000_8010);

    // R8 present state readback
    for (int p = 0; p < 4; p++) begin
      ps_intr = p[0]; ps_gwake = p[1];
      wr(8'hF8, 32'hFFFF_FFFF);
      rd(8'hF8, v);
      chk("R8 present state", v, (32'(p[0]) << 15) | (32'(p[1]) << 4));
    end
    ps_gwake = 1'b0; ps_intr = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'hF0, 32'h0000_8010);

    // R9 R10 R11 routing sweep
    for (int c = 0; c < 128; c++) begin
      logic pw, im, wk, gm, ei, eg, pi, exp_int_n, exp_wake;
      pw = c[0]; im = c[1]; wk = c[2]; gm = c[3];
      ei = c[4]; eg = c[5]; pi = c[6];
      wr(8'hF4, (32'(im) << 15) | (32'(wk) << 14) | (32'(gm) << 4));
      wr(8'hF0, 32'h0000_8010);
      wr(8'hFC, (32'(ei) << 15) | (32'(eg) << 4));
      pwr_on = pw; ps_intr = pi;
      repeat (3) @(negedge clk);
      exp_int_n = !(pw && im && (ei || pi));
      exp_wake  = wk && ((gm && eg) || (!pw && im && (ei || pi)));
      if (!pw) chk("R11 int_n unpowered", {31'd0, int_n}, 32'd1);
      else     chk("R9 int_n", {31'd0, int_n}, {31'd0, exp_int_n});
      chk("R10 wake", {31'd0, wake}, {31'd0, exp_wake});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule